// File: doc/BRIEF.md
# I2C Master Command Controller

This block is a single-master I2C controller that software drives through a small register window. A host writes the target's 7-bit address and a direction flag, optionally a data byte, and then one command word. In that word the START, RUN and STOP requests are separate bits. The controller then performs the requested phases on the open-drain SCL and SDA lines. The phases are a start condition with the address byte, one data byte in either direction, and a stop condition.

The controller remembers whether it currently owns the bus. A transfer can therefore be split over several command writes, for example START+RUN, then RUN, then RUN+STOP. Status bits report whether a phase is in progress and whether the bus is owned. They also report a missing acknowledge after the address or after a written byte, a lost arbitration bit, and an error. Each completed byte raises a raw interrupt that can be masked and cleared.

The pins are modelled as drive-low enables. A 1 on `scl_oe` or `sda_oe` pulls the line low, and a 0 releases it to the pull-up. Register reads have one cycle of latency: `bus_rdata` shows the register addressed in the previous cycle.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset the period register (offset 0x0C) reads 1, and the address (0x00), data (0x08), mask (0x10), raw (0x14), masked (0x18) and configuration (0x20) registers read 0. Status (0x04) reads 0x20, both line enables are 0 and `irq` is 0.
- R2: A configuration write keeps only the bits in 0x31. A command write to 0x04 is ignored while configuration bit 4 is 0: no line activity follows and status stays unchanged.
- R3: Command bit 1 requests a start. If the bus is not owned, the controller sends a start condition and then the address register MSB first. Bits 7:1 of that register are the target address and bit 0 is the direction, where 1 means read. An acknowledged address sets status bit 6 and clears status bit 4. A start request while the bus is owned sends no start condition.
- R4: An address that is not acknowledged sets status bits 2 and 1, is followed by a stop condition, and leaves status bit 6 at 0.
- R5: If SDA reads low while the controller leaves it released during an address bit, status bits 4 and 1 are set. The controller then stops and releases both lines.
- R6: If the bus is not owned once the start phase is done, or when no start was requested, status bit 1 is set. No byte is moved and the raw interrupt is not set.
- R7: RUN (command bit 0) with direction 0 sends the data register MSB first. A missing acknowledge sets status bits 3 and 1.
- R8: RUN with direction 1 receives a byte into the data register. The controller acknowledges the byte unless the same command also carries STOP, in which case it does not acknowledge.
- R9: Each completed RUN byte sets raw interrupt bit 0. The masked register reads raw AND mask bit 0, and `irq` follows that value. Writing 1 to bit 0 of 0x1C clears the raw bit.
- R10: STOP (command bit 2) sends a stop condition and clears status bit 6. While the bus is owned between commands, SCL is held low.
- R11: The SCL period during a byte is DIV_BASE × (period register + 1) clocks.
- R12: Status bit 0 is 1 while a command is being carried out. Status bit 5 is 1 only when the controller is not busy and does not own the bus, and both lines are released in that state.
- R13: The address and data registers read back the full byte written. The period register reads back its written value, and the mask register keeps bit 0 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset presented one cycle earlier |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Masked byte-complete interrupt |

## Verification
The bench builds the controller with DIV_BASE = 4. That makes a quarter bit one clock at period value 0, so a full address-plus-data-plus-stop transfer takes well under a few hundred cycles. This short timing lets the bench sweep period values 0 to 3 against several data patterns in both directions and check the measured SCL period arithmetically. It also exercises split transactions, missing acknowledges at both points, forced arbitration loss, and commands issued without bus ownership or with the controller disabled.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int BYTE_W = 8;

  localparam int OFS_SADDR  = 'h00;
  localparam int OFS_CMD    = 'h04;
  localparam int OFS_DATA   = 'h08;
  localparam int OFS_PERIOD = 'h0C;
  localparam int OFS_IMASK  = 'h10;
  localparam int OFS_RAW    = 'h14;
  localparam int OFS_MASKED = 'h18;
  localparam int OFS_ICLR   = 'h1C;
  localparam int OFS_CFG    = 'h20;

  localparam logic [BYTE_W-1:0] CFG_KEEP = 8'h31;
  localparam int EN_BIT = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_START, ST_ABYTE, ST_DBYTE, ST_STOP
  } ctl_state_e;
endpackage

// File: rtl/i2c_qtick.sv
// Quarter-bit strobe: one pulse every QUART*(prd+1) clocks while run is high.
module i2c_qtick #(
  parameter int QUART = 5,
  parameter int PRD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRD_W-1:0] prd,
  output logic             qtick
);
  localparam int CNT_W = PRD_W + $clog2(QUART + 1) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(QUART) * (CNT_W'(prd) + CNT_W'(1)) - CNT_W'(1);
  assign qtick = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || qtick) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_shreg.sv
// Byte shifter: parallel load, MSB-first shift with serial fill.
module i2c_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int PRD_W    = 8,
  parameter int DIV_BASE = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq
);
  localparam int QUART = DIV_BASE / 4;
  localparam logic [3:0] ACK_SLOT = 4'd8;

  ctl_state_e        state;
  logic [BYTE_W-1:0] saddr, mdata, cfg, sh_q, sh_din, status;
  logic [PRD_W-1:0]  prd;
  logic              imask, raw;
  logic              err, adr_nak, dat_nak, arb, held;
  logic              run_p, stop_p, samp;
  logic [1:0]        q;
  logic [3:0]        bitn;
  logic              busy, cmd_hit, accept, timed, qtick;
  logic              sh_load, sh_shift, rd_dir, in_byte;
  logic              scl_lvl, sda_lvl;

  assign busy    = (state != ST_IDLE);
  assign cmd_hit = bus_we && (bus_addr == ADDR_W'(OFS_CMD));
  assign accept  = cmd_hit && cfg[EN_BIT] && !busy;
  assign timed   = (state == ST_START) || (state == ST_ABYTE) ||
                   (state == ST_DBYTE) || (state == ST_STOP);
  assign rd_dir  = saddr[0];
  assign in_byte = (state == ST_ABYTE) || (state == ST_DBYTE);
  assign status  = {1'b0, held, !busy && !held, arb, dat_nak, adr_nak, err, busy};

  assign sh_load  = accept || (state == ST_CHECK && held && run_p);
  assign sh_din   = (state == ST_IDLE) ? saddr : (rd_dir ? 8'hFF : mdata);
  assign sh_shift = in_byte && qtick && (q == 2'd3) && (bitn != ACK_SLOT);

  i2c_qtick #(.QUART(QUART), .PRD_W(PRD_W)) u_qtick (
    .clk(clk), .rst(rst), .run(timed), .prd(prd), .qtick(qtick)
  );

  i2c_shreg #(.W(BYTE_W)) u_shreg (
    .clk(clk), .rst(rst), .load(sh_load), .din(sh_din),
    .shift(sh_shift), .sin(samp), .q(sh_q)
  );

  // Register writes and command sequencing.
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      saddr <= '0; mdata <= '0; cfg <= '0; prd <= PRD_W'(1);
      imask <= 1'b0; raw <= 1'b0;
      err <= 1'b0; adr_nak <= 1'b0; dat_nak <= 1'b0; arb <= 1'b0; held <= 1'b0;
      run_p <= 1'b0; stop_p <= 1'b0; samp <= 1'b0; q <= '0; bitn <= '0;
    end else begin
      if (bus_we) begin
        case (bus_addr)
          ADDR_W'(OFS_SADDR):  saddr <= bus_wdata;
          ADDR_W'(OFS_DATA):   mdata <= bus_wdata;
          ADDR_W'(OFS_PERIOD): prd   <= PRD_W'(bus_wdata);
          ADDR_W'(OFS_IMASK):  imask <= bus_wdata[0];
          ADDR_W'(OFS_ICLR):   if (bus_wdata[0]) raw <= 1'b0;
          ADDR_W'(OFS_CFG):    cfg   <= bus_wdata & CFG_KEEP;
          default: ;
        endcase
      end
      case (state)
        ST_IDLE: if (accept) begin
          err <= 1'b0; adr_nak <= 1'b0; dat_nak <= 1'b0;
          run_p <= bus_wdata[0]; stop_p <= bus_wdata[2];
          q <= '0; bitn <= '0;
          state <= (bus_wdata[1] && !held) ? ST_START : ST_CHECK;
        end
        ST_CHECK: begin
          q <= '0; bitn <= '0;
          if (!held) begin
            err <= 1'b1; state <= ST_IDLE;
          end else if (run_p)  state <= ST_DBYTE;
          else if (stop_p)     state <= ST_STOP;
          else                 state <= ST_IDLE;
        end
        ST_START: if (qtick) begin
          q <= q + 1'b1;
          if (q == 2'd3) begin bitn <= '0; state <= ST_ABYTE; end
        end
        ST_ABYTE, ST_DBYTE: if (qtick) begin
          q <= q + 1'b1;
          if (q == 2'd2) begin
            samp <= sda_in;
            if (state == ST_ABYTE && bitn != ACK_SLOT && sh_q[BYTE_W-1] && !sda_in) begin
              arb <= 1'b1; err <= 1'b1; state <= ST_IDLE;
            end
          end
          if (q == 2'd3 && bitn != ACK_SLOT) bitn <= bitn + 1'b1;
          if (q == 2'd3 && bitn == ACK_SLOT) begin
            if (state == ST_ABYTE) begin
              if (!samp) begin held <= 1'b1; arb <= 1'b0; state <= ST_CHECK; end
              else begin adr_nak <= 1'b1; err <= 1'b1; state <= ST_STOP; end
            end else begin
              raw <= 1'b1;
              if (rd_dir) mdata <= sh_q;
              else if (samp) begin dat_nak <= 1'b1; err <= 1'b1; end
              state <= stop_p ? ST_STOP : ST_IDLE;
            end
          end
        end
        ST_STOP: if (qtick) begin
          q <= q + 1'b1;
          if (q == 2'd3) begin held <= 1'b0; state <= ST_IDLE; end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Line levels per phase and quarter.
  always_comb begin
    scl_lvl = 1'b1;
    sda_lvl = 1'b1;
    case (state)
      ST_IDLE, ST_CHECK: scl_lvl = !held;
      ST_START: begin scl_lvl = (q < 2'd2); sda_lvl = (q == 2'd0); end
      ST_ABYTE: begin
        scl_lvl = (q == 2'd1) || (q == 2'd2);
        sda_lvl = (bitn == ACK_SLOT) ? 1'b1 : sh_q[BYTE_W-1];
      end
      ST_DBYTE: begin
        scl_lvl = (q == 2'd1) || (q == 2'd2);
        if (bitn == ACK_SLOT) sda_lvl = rd_dir ? stop_p : 1'b1;
        else                  sda_lvl = rd_dir ? 1'b1 : sh_q[BYTE_W-1];
      end
      ST_STOP: begin scl_lvl = (q != 2'd0); sda_lvl = (q >= 2'd2); end
      default: ;
    endcase
  end

  // Registered outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_oe <= 1'b0; sda_oe <= 1'b0; irq <= 1'b0; bus_rdata <= '0;
    end else begin
      scl_oe <= !scl_lvl;
      sda_oe <= !sda_lvl;
      irq    <= raw & imask;
      case (bus_addr)
        ADDR_W'(OFS_SADDR):  bus_rdata <= saddr;
        ADDR_W'(OFS_CMD):    bus_rdata <= status;
        ADDR_W'(OFS_DATA):   bus_rdata <= mdata;
        ADDR_W'(OFS_PERIOD): bus_rdata <= BYTE_W'(prd);
        ADDR_W'(OFS_IMASK):  bus_rdata <= {7'b0, imask};
        ADDR_W'(OFS_RAW):    bus_rdata <= {7'b0, raw};
        ADDR_W'(OFS_MASKED): bus_rdata <= {7'b0, raw & imask};
        ADDR_W'(OFS_CFG):    bus_rdata <= cfg;
        default:             bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic held,
  input logic raw,
  input logic scl_oe,
  input logic sda_oe,
  input logic cmd_hit,
  input logic en
);
  assert_disabled_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && !en && !busy) |=> !busy);

  assert_released_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (!busy && !held && $past(!busy && !held)) |-> (!scl_oe && !sda_oe));

  assert_scl_low_owned_R10: assert property (@(posedge clk) disable iff (rst)
    (held && !busy && $past(held && !busy)) |-> scl_oe);

  assert_raw_after_byte_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(raw) |-> $past(busy));

  assert_own_after_phase_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(held) |-> $past(busy));
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .held(held), .raw(raw),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .cmd_hit(cmd_hit), .en(cfg[4])
);

// File: tb/sim_i2c_cmd_master.sv
module sim_i2c_cmd_master;
  localparam int DIVB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5ns clk = ~clk;

  logic [5:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       scl_oe, sda_oe, irq;
  logic       s_sda_low = 1'b0;
  logic       force_low = 1'b0;
  wire        scl = !scl_oe;
  wire        sda = !(sda_oe || s_sda_low || force_low);

  i2c_cmd_master #(.ADDR_W(6), .PRD_W(8), .DIV_BASE(DIVB)) u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .sda_in(sda), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk) cyc++;

  // Target model.
  logic [6:0] slv_addr = 7'h2A;
  logic       data_nack = 1'b0;
  logic [7:0] rd_val = 8'h00;
  logic [7:0] sh = '0, rsh = '0, last_wr = '0;
  logic       in_addr = 1'b0, addressed = 1'b0, rd_mode = 1'b0, m_nack = 1'b1;
  int cnt = 0, starts = 0, stops = 0, wr_count = 0, rises = 0, t_prev = 0, t_last = 0;

  always @(negedge sda) if (scl) begin
    starts++; cnt = 0; in_addr = 1'b1; addressed = 1'b0; s_sda_low = 1'b0;
  end
  always @(posedge sda) if (scl) begin
    stops++; in_addr = 1'b0; addressed = 1'b0; s_sda_low = 1'b0;
  end
  always @(posedge scl) begin
    rises++; t_prev = t_last; t_last = cyc;
    if (cnt < 8) sh = {sh[6:0], sda};
    else if (cnt == 8) m_nack = sda;
    cnt++;
  end
  always @(negedge scl) begin
    if (cnt == 8) begin
      if (in_addr) begin
        addressed = (sh[7:1] == slv_addr); rd_mode = sh[0]; s_sda_low = addressed;
      end else if (addressed && !rd_mode) begin
        last_wr = sh; wr_count++; s_sda_low = !data_nack;
      end else s_sda_low = 1'b0;
    end else if (cnt == 9) begin
      s_sda_low = 1'b0; cnt = 0;
      if (addressed && rd_mode && (in_addr || !m_nack)) begin
        rsh = rd_val; s_sda_low = !rsh[7];
      end
      in_addr = 1'b0;
    end else if (addressed && rd_mode && !in_addr && cnt >= 1 && cnt <= 7) begin
      s_sda_low = !rsh[7-cnt];
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    @(posedge clk); @(negedge clk); d = rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(6'h04, s);
      if (!s[0]) return;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    int e0, s0, p0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(6'h00, v); chk("R1 saddr", v, 8'h00);
    rd(6'h04, v); chk("R1 status", v, 8'h20);
    rd(6'h08, v); chk("R1 data", v, 8'h00);
    rd(6'h0C, v); chk("R1 period", v, 8'h01);
    rd(6'h10, v); chk("R1 mask", v, 8'h00);
    rd(6'h14, v); chk("R1 raw", v, 8'h00);
    rd(6'h18, v); chk("R1 masked", v, 8'h00);
    rd(6'h20, v); chk("R1 cfg", v, 8'h00);
    chk("R1 lines irq", {scl_oe, sda_oe, irq}, 3'b000);

    // R2 config mask and disabled command
    wr(6'h20, 8'hFF); rd(6'h20, v); chk("R2 cfg keep", v, 8'h31);
    wr(6'h20, 8'h00); wr(6'h00, {slv_addr, 1'b0});
    e0 = rises;
    wr(6'h04, 8'h07); repeat (50) @(negedge clk);
    rd(6'h04, v); chk("R2 disabled status", v, 8'h20);
    chk("R2 disabled no scl", rises, e0);
    wr(6'h20, 8'h10);

    // R13 readback
    wr(6'h00, 8'h5A); rd(6'h00, v); chk("R13 saddr", v, 8'h5A);
    wr(6'h08, 8'hC3); rd(6'h08, v); chk("R13 data", v, 8'hC3);
    wr(6'h0C, 8'h03); rd(6'h0C, v); chk("R13 period", v, 8'h03);
    wr(6'h10, 8'hFE); rd(6'h10, v); chk("R13 mask bit0 only", v, 8'h00);

    // R6 run without ownership
    e0 = rises;
    wr(6'h04, 8'h01); wait_idle();
    rd(6'h04, v); chk("R6 status", v, 8'h22);
    rd(6'h14, v); chk("R6 raw", v, 8'h00);
    chk("R6 no scl", rises, e0);

    // R7 R11 R9 R10 write sweep
    wr(6'h00, {slv_addr, 1'b0});
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] d;
        d = (k == 0) ? 8'h00 : (k == 1) ? 8'hA5 : (k == 2) ? 8'hFF : 8'(p * 37 + 1);
        wr(6'h0C, 8'(p)); wr(6'h08, d);
        s0 = stops;
        wr(6'h04, 8'h07);
        if (k == 0) begin
          rd(6'h04, v); chk("R12 busy while running", v & 8'h21, 8'h01);
        end
        wait_idle();
        chk("R7 byte sent", last_wr, d);
        chk("R11 scl period", t_last - t_prev, DIVB * (p + 1));
        chk("R10 stop seen", stops - s0, 1);
        rd(6'h04, v); chk("R10 status idle", v, 8'h20);
        rd(6'h14, v); chk("R9 raw set", v, 8'h01);
        wr(6'h1C, 8'h01); rd(6'h14, v); chk("R9 raw cleared", v, 8'h00);
      end
    end

    // R8 read sweep, single command with stop
    wr(6'h0C, 8'h00);
    wr(6'h00, {slv_addr, 1'b1});
    for (int k = 0; k < 6; k++) begin
      rd_val = 8'(8'h3C ^ (k * 53));
      wr(6'h04, 8'h07); wait_idle();
      rd(6'h08, v); chk("R8 read data", v, rd_val);
      chk("R8 nack last", m_nack, 1'b1);
      rd(6'h04, v); chk("R8 status", v, 8'h20);
    end

    // R8 R3 split read
    rd_val = 8'h96;
    wr(6'h04, 8'h03); wait_idle();
    rd(6'h04, v); chk("R3 owned status", v, 8'h40);
    rd(6'h08, v); chk("R8 split first", v, 8'h96);
    chk("R8 ack when continuing", m_nack, 1'b0);
    wr(6'h04, 8'h05); wait_idle();
    rd(6'h08, v); chk("R8 split second", v, 8'h96);
    chk("R8 nack with stop", m_nack, 1'b1);
    rd(6'h04, v); chk("R10 split status", v, 8'h20);

    // R3 start while owned, R10 standalone stop
    wr(6'h00, {slv_addr, 1'b0});
    wr(6'h08, 8'h11); wr(6'h04, 8'h03); wait_idle();
    chk("R3 first byte", last_wr, 8'h11);
    s0 = starts; p0 = stops;
    wr(6'h08, 8'h22); wr(6'h04, 8'h03); wait_idle();
    chk("R3 no second start", starts, s0);
    chk("R7 second byte", last_wr, 8'h22);
    rd(6'h04, v); chk("R3 still owned", v, 8'h40);
    chk("R10 scl held low", scl_oe, 1'b1);
    wr(6'h04, 8'h04); wait_idle();
    chk("R10 stop count", stops - p0, 1);
    rd(6'h04, v); chk("R10 released status", v, 8'h20);
    chk("R12 lines released", {scl_oe, sda_oe}, 2'b00);

    // R9 interrupt path
    wr(6'h1C, 8'h01);
    wr(6'h10, 8'h01);
    wr(6'h08, 8'h5C); wr(6'h04, 8'h07); wait_idle();
    rd(6'h18, v); chk("R9 masked", v, 8'h01);
    chk("R9 irq high", irq, 1'b1);
    wr(6'h1C, 8'h01); repeat (2) @(negedge clk);
    chk("R9 irq low", irq, 1'b0);
    wr(6'h10, 8'h00);

    // R4 address not acknowledged
    wr(6'h00, {7'h11, 1'b0});
    p0 = stops;
    wr(6'h04, 8'h07); wait_idle();
    rd(6'h04, v); chk("R4 status", v, 8'h26);
    rd(6'h14, v); chk("R4 raw", v, 8'h00);
    chk("R4 stop sent", stops - p0, 1);

    // R7 data not acknowledged
    wr(6'h00, {slv_addr, 1'b0});
    data_nack = 1'b1;
    wr(6'h08, 8'h77); wr(6'h04, 8'h07); wait_idle();
    rd(6'h04, v); chk("R7 data nack status", v, 8'h2A);
    rd(6'h14, v); chk("R9 raw after nack", v, 8'h01);
    data_nack = 1'b0; wr(6'h1C, 8'h01);

    // R5 arbitration lost, then R3 clears it
    wr(6'h00, 8'hA4);
    force_low = 1'b1;
    wr(6'h04, 8'h03); wait_idle();
    rd(6'h04, v); chk("R5 status", v, 8'h32);
    repeat (2) @(negedge clk);
    chk("R5 lines released", {scl_oe, sda_oe}, 2'b00);
    force_low = 1'b0;
    wr(6'h00, {slv_addr, 1'b0});
    wr(6'h08, 8'h3E); wr(6'h04, 8'h07); wait_idle();
    rd(6'h04, v); chk("R3 arb cleared", v, 8'h20);
    chk("R3 byte after arb", last_wr, 8'h3E);

    summary();
    $finish;
  end
endmodule